// File: doc/BRIEF.md
# LIN Slave Header Receiver with Break Generator

This block handles the header part of a LIN frame on the receive side of a slave node. It watches the serial line for a dominant run long enough to count as a break. It then times the synchronisation byte to learn the bit period the master is actually using, and receives the protected identifier at that rate. It checks the identifier's two parity bits and reports one result per header: the header completed, a parity error, a synch error or a header timeout. A break that arrives in the middle of a header discards that header and starts a new one.

For a node that acts as master, the block can also drive a break of 13 nominal bit times on its own transmit output when asked. The receive line is taken as already synchronous to `clk`, with 1 as recessive and 0 as dominant. Response bytes and the checksum are handled outside the block.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset, `tx` is 1, `bit_period` equals `NOM_BIT`, `hdr_id` is 0, and none of `hdr_done`, `par_err`, `sync_err` or `timeout` is set.
- R2: A break is recognised once `rx` has been 0 for 11·`NOM_BIT` consecutive clocks, in any state. A shorter dominant run (for example 10 bit times) starts no header, so the synch and identifier bytes that follow it produce no result.
- R3: After the break and a recessive delimiter, the clocks from the first falling edge to the fifth falling edge of the synch byte (0x55, LSB first) are counted. That count divided by 8 becomes the new `bit_period`. `bit_period` changes at no other time.
- R4: If the measured period differs from `NOM_BIT` by more than `NOM_BIT`/7, then `sync_err` pulses, `bit_period` keeps its old value, and the rest of the header is ignored.
- R5: The identifier byte is received LSB first at the measured rate. The start bit is sampled at half a period and each data bit one period after the previous sample. `hdr_id` shows bits 5..0 of the byte.
- R6: Parity uses bit 6 = id0^id1^id2^id4 and bit 7 = NOT(id1^id3^id4^id5). A matching byte pulses `hdr_done`. A mismatching byte pulses `par_err` instead. In both cases `hdr_id` is updated.
- R7: If a header is not complete 48 nominal bit times after its break began, `timeout` pulses and the block goes back to waiting for a break.
- R8: A break recognised partway through a header abandons that header without reporting a result, and restarts synch measurement and the timeout.
- R9: A one-cycle `brk_req` while no break is being sent drives `tx` to 0 for exactly 13·`NOM_BIT` clocks, with `brk_busy` high for that time. A request that arrives while a break is being sent is ignored.
- R10: Each result flag is a one-clock pulse, and at most one of the four is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Synchronous receive line, 0 = dominant |
| brk_req | input | 1 | One-cycle request to send a break |
| tx | output | 1 | Transmit line, 0 while a break is sent |
| brk_busy | output | 1 | High while a break is being sent |
| bit_period | output | CNT_W | Receive bit period in clocks |
| hdr_id | output | 6 | Last received identifier, bits 5..0 |
| hdr_done | output | 1 | Header received with good parity |
| par_err | output | 1 | Identifier parity mismatch |
| sync_err | output | 1 | Synch measurement out of tolerance |
| timeout | output | 1 | Header not finished in time |

## Verification
The assertions check the following on every cycle:
- At most one result flag is high in any cycle.
- `bit_period` moves only at the end of a synch measurement, and stays put when a synch error is raised.
- A completed header always carries consistent parity bits.
- The timeout counter never passes its limit while a header is active.
- Every transmitted break is exactly 13 bit times long.

Other behaviour can only be shown by the bench's scenarios, using a scoreboard of expected results:
- Identifier bits are sampled correctly at fast, slow and nominal rates.
- A 10-bit dominant run is ignored.
- A break inside a synch byte discards that header.
- A header stalled after the synch byte ends in a timeout.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRKW,
        ST_DELIM,
        ST_SYNC,
        ST_PIDW,
        ST_PID
    } hdr_st_t;

    localparam int SYNC_FALLS = 5;   // falling edges spanned by the measurement
    localparam int TOL_DIV    = 7;   // tolerance = nominal / TOL_DIV
    localparam int RX_BRK     = 11;  // bit times for break recognition
    localparam int TX_BRK     = 13;  // bit times for a generated break
    localparam int HDR_LIMIT  = 48;  // ~1.4 x 34 bit times

endpackage

// File: rtl/lin_pid_chk.sv
module lin_pid_chk (
    input  logic [7:0] pid,
    output logic       ok
);
    logic p_lo;
    logic p_hi;

    always_comb begin
        p_lo = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
        p_hi = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
        ok   = (pid[6] == p_lo) && (pid[7] == p_hi);
    end
endmodule

// File: rtl/lin_hdr_timer.sv
module lin_hdr_timer #(
    parameter int CNT_W = 16,
    parameter int START = 176,
    parameter int LIMIT = 768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic lapse
);
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(START);
        end else if (run) begin
            cnt_d = cnt_q + 1'b1;
        end
        lapse = run && !load && (cnt_q == CNT_W'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CNT_W'(LIMIT))) else $error("timer past limit"); // R7
endmodule

// File: rtl/lin_brk_gen.sv
module lin_brk_gen #(
    parameter int CNT_W   = 16,
    parameter int BRK_CYC = 208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic tx,
    output logic busy
);
    logic [CNT_W-1:0] left_d;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] low_run_q;

    always_comb begin
        left_d = left_q;
        if (left_q != '0) begin
            left_d = left_q - 1'b1;
        end else if (req) begin
            left_d = CNT_W'(BRK_CYC);
        end
        busy = (left_q != '0);
        tx   = ~busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    // independent run-length of the transmitted dominant level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  low_run_q <= '0;
        else if (tx) low_run_q <= '0;
        else         low_run_q <= low_run_q + 1'b1;
    end

    AST_BRK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx) |-> (low_run_q == CNT_W'(BRK_CYC))) else $error("break length"); // R9
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int NOM_BIT = 16,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx,
    input  logic             brk_req,
    output logic             tx,
    output logic             brk_busy,
    output logic [CNT_W-1:0] bit_period,
    output logic [5:0]       hdr_id,
    output logic             hdr_done,
    output logic             par_err,
    output logic             sync_err,
    output logic             timeout
);
    localparam int BRK_LIM = RX_BRK * NOM_BIT;
    localparam int TO_LIM  = HDR_LIMIT * NOM_BIT;
    localparam int TX_CYC  = TX_BRK * NOM_BIT;
    localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOM_BIT);

    typedef struct packed {
        hdr_st_t          state;
        logic             rx_prev;
        logic [CNT_W-1:0] dom;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       falls;
        logic [3:0]       bitidx;
        logic [7:0]       shreg;
        logic [7:0]       pid;
        logic [CNT_W-1:0] period;
        logic             done;
        logic             perr;
        logic             serr;
        logic             tmo;
    } hdr_regs_t;

    hdr_regs_t r_d;
    hdr_regs_t r_q;

    logic             fall;
    logic             brk_hit;
    logic             lapse;
    logic             tmr_load;
    logic             tmr_run;
    logic [CNT_W-1:0] meas;
    logic [CNT_W-1:0] dev;
    logic [CNT_W+2:0] dev_x7;
    logic             meas_bad;
    logic [CNT_W-1:0] tgt;
    logic [7:0]       pid_byte;
    logic             pid_ok;

    lin_pid_chk u_pid (
        .pid (pid_byte),
        .ok  (pid_ok)
    );

    lin_hdr_timer #(
        .CNT_W (CNT_W),
        .START (BRK_LIM),
        .LIMIT (TO_LIM)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .lapse (lapse)
    );

    lin_brk_gen #(
        .CNT_W   (CNT_W),
        .BRK_CYC (TX_CYC)
    ) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (brk_req),
        .tx    (tx),
        .busy  (brk_busy)
    );

    always_comb begin
        fall     = r_q.rx_prev && !rx;
        brk_hit  = !rx && (r_q.dom == CNT_W'(BRK_LIM - 1));
        meas     = r_q.cnt >> 3;
        dev      = (meas > NOM_C) ? (meas - NOM_C) : (NOM_C - meas);
        dev_x7   = {3'b000, dev} * (CNT_W+3)'(TOL_DIV);
        meas_bad = dev_x7 > {3'b000, NOM_C};
        tgt      = (r_q.bitidx == 4'd0) ? (r_q.period >> 1) : r_q.period;
        pid_byte = {rx, r_q.shreg[7:1]};
        tmr_run  = (r_q.state != ST_IDLE);
        tmr_load = brk_hit;

        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.perr    = 1'b0;
        r_d.serr    = 1'b0;
        r_d.tmo     = 1'b0;
        r_d.rx_prev = rx;
        if (rx)            r_d.dom = '0;
        else if (&r_q.dom) r_d.dom = r_q.dom;
        else               r_d.dom = r_q.dom + 1'b1;

        if (brk_hit) begin
            r_d.state = ST_BRKW;
        end else if (lapse) begin
            r_d.state = ST_IDLE;
            r_d.tmo   = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_IDLE: ;
                ST_BRKW: begin
                    if (rx) r_d.state = ST_DELIM;
                end
                ST_DELIM: begin
                    if (fall) begin
                        r_d.state = ST_SYNC;
                        r_d.cnt   = CNT_W'(1);
                        r_d.falls = 3'd1;
                    end
                end
                ST_SYNC: begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (fall) begin
                        if (r_q.falls == 3'(SYNC_FALLS - 1)) begin
                            if (meas_bad) begin
                                r_d.serr  = 1'b1;
                                r_d.state = ST_IDLE;
                            end else begin
                                r_d.period = meas;
                                r_d.state  = ST_PIDW;
                            end
                        end else begin
                            r_d.falls = r_q.falls + 1'b1;
                        end
                    end
                end
                ST_PIDW: begin
                    if (fall) begin
                        r_d.state  = ST_PID;
                        r_d.cnt    = CNT_W'(1);
                        r_d.bitidx = 4'd0;
                    end
                end
                ST_PID: begin
                    if (r_q.cnt == tgt) begin
                        r_d.cnt = CNT_W'(1);
                        if (r_q.bitidx == 4'd0) begin
                            if (rx) r_d.state  = ST_IDLE;
                            else    r_d.bitidx = 4'd1;
                        end else begin
                            r_d.shreg = pid_byte;
                            if (r_q.bitidx == 4'd8) begin
                                r_d.pid   = pid_byte;
                                r_d.state = ST_IDLE;
                                if (pid_ok) r_d.done = 1'b1;
                                else        r_d.perr = 1'b1;
                            end else begin
                                r_d.bitidx = r_q.bitidx + 1'b1;
                            end
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= ST_IDLE;
            r_q.rx_prev <= 1'b1;
            r_q.period  <= NOM_C;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_period = r_q.period;
    assign hdr_id     = r_q.pid[5:0];
    assign hdr_done   = r_q.done;
    assign par_err    = r_q.perr;
    assign sync_err   = r_q.serr;
    assign timeout    = r_q.tmo;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_done, par_err, sync_err, timeout})) else $error("multiple results"); // R10
    AST_PERIOD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_period) |-> ($past(r_q.state) == ST_SYNC)) else $error("period moved"); // R3
    AST_SYNC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> $stable(bit_period)) else $error("period changed on synch error"); // R4
    AST_DONE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> ((r_q.pid[6] == (r_q.pid[0] ^ r_q.pid[1] ^ r_q.pid[2] ^ r_q.pid[4])) &&
                      (r_q.pid[7] != (r_q.pid[1] ^ r_q.pid[3] ^ r_q.pid[4] ^ r_q.pid[5]))))
        else $error("done with bad parity"); // R6
    AST_TMO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> ($past(r_q.state) != ST_IDLE)) else $error("timeout while idle"); // R7
    AST_BRK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> (r_q.state == ST_BRKW)) else $error("break not taken"); // R8
endmodule

// File: tb/lin_hdr_rx_test.sv
module lin_hdr_rx_test;
    localparam int CLK_T = 10;
    localparam int NOM   = 16;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic          brk_req = 1'b0;
    logic          tx;
    logic          brk_busy;
    logic [CW-1:0] bit_period;
    logic [5:0]    hdr_id;
    logic          hdr_done;
    logic          par_err;
    logic          sync_err;
    logic          timeout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int kind;   // 0 done, 1 parity, 2 synch, 3 timeout
        int id;
        int per;
        string req;
    } exp_t;
    exp_t sb[$];

    lin_hdr_rx #(.NOM_BIT(NOM), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .rx(rx), .brk_req(brk_req),
        .tx(tx), .brk_busy(brk_busy), .bit_period(bit_period), .hdr_id(hdr_id),
        .hdr_done(hdr_done), .par_err(par_err), .sync_err(sync_err), .timeout(timeout)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_pid(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int p);
        hold(1'b0, p);
        for (int i = 0; i < 8; i++) hold(b[i], p);
        hold(1'b1, p);
    endtask

    task automatic header(input int p, input logic [7:0] pid);
        hold(1'b0, 13 * NOM);
        hold(1'b1, NOM);
        send_byte(8'h55, p);
        send_byte(pid, p);
        hold(1'b1, 3 * p);
    endtask

    task automatic expect_ev(input int kind, input int id, input int per, input string req);
        exp_t e;
        e.kind = kind; e.id = id; e.per = per; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n) begin
            int n;
            int kind;
            exp_t e;
            n = $countones({hdr_done, par_err, sync_err, timeout});
            if (n > 1) check(1'b0, "R10 one result", n, 1);
            if (n != 0) begin
                kind = hdr_done ? 0 : par_err ? 1 : sync_err ? 2 : 3;
                if (sb.size() == 0) begin
                    check(1'b0, "R2/R8 unexpected result", kind, -1);
                end else begin
                    e = sb.pop_front();
                    check(kind == e.kind, {e.req, " kind"}, kind, e.kind);
                    if (kind < 2) check(int'(hdr_id) == e.id, {e.req, " id"}, int'(hdr_id), e.id);
                    check(int'(bit_period) == e.per, {e.req, " period"}, int'(bit_period), e.per);
                end
            end
        end
    end

    initial begin
        #(CLK_T * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int low;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(tx == 1'b1, "R1 tx", int'(tx), 1);
        check(int'(bit_period) == NOM, "R1 period", int'(bit_period), NOM);
        check(hdr_id == 6'd0, "R1 id", int'(hdr_id), 0);
        check({hdr_done, par_err, sync_err, timeout} == 4'b0, "R1 flags",
              int'({hdr_done, par_err, sync_err, timeout}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R5 R6 good headers at several rates
        expect_ev(0, 6'h12, 16, "R5 nominal");
        header(16, mk_pid(6'h12));
        expect_ev(0, 6'h3A, 18, "R3 slow");
        header(18, mk_pid(6'h3A));
        expect_ev(0, 6'h05, 14, "R3 fast");
        header(14, mk_pid(6'h05));
        // R6 parity mismatch (bit 7 flipped)
        expect_ev(1, 6'h21, 16, "R6 parity");
        header(16, mk_pid(6'h21) ^ 8'h80);
        // R4 synch out of tolerance both ways, period kept
        expect_ev(2, 0, 16, "R4 too slow");
        header(20, mk_pid(6'h07));
        expect_ev(2, 0, 16, "R4 too fast");
        header(12, mk_pid(6'h07));

        // R2 10-bit dominant run is not a break
        hold(1'b0, 10 * NOM);
        hold(1'b1, NOM);
        send_byte(8'h55, 16);
        send_byte(mk_pid(6'h11), 16);
        hold(1'b1, 100);
        check(sb.size() == 0, "R2 short break ignored", sb.size(), 0);
        check(int'(bit_period) == 16, "R2 period untouched", int'(bit_period), 16);

        // R8 break inside the synch byte restarts the header
        hold(1'b0, 13 * NOM);
        hold(1'b1, NOM);
        hold(1'b0, 16);
        hold(1'b1, 16);
        expect_ev(0, 6'h0F, 17, "R8 restart");
        header(17, mk_pid(6'h0F));

        // R7 header stalls after synch
        expect_ev(3, 0, 16, "R7 timeout");
        hold(1'b0, 13 * NOM);
        hold(1'b1, NOM);
        send_byte(8'h55, 16);
        hold(1'b1, 1000);

        check(sb.size() == 0, "R7 all results seen", sb.size(), 0);

        // R9 master break, second request ignored
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        low = 0;
        for (int i = 0; i < 400; i++) begin
            if (i == 50) brk_req = 1'b1;
            if (i == 51) brk_req = 1'b0;
            if (!tx) low++;
            @(negedge clk);
        end
        check(low == 13 * NOM, "R9 break length", low, 13 * NOM);
        check(tx == 1'b1 && !brk_busy, "R9 tx released", int'(tx), 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule